// File: doc/BRIEF.md
# Link-Aware Shift and Rotate Unit

This block holds a small bank of accumulators and a single link bit, and performs one-bit shifts and rotates on a chosen accumulator. Each execute strobe names one accumulator and one of four operations: shift left, shift right, rotate left or rotate right. The result is written back to the same accumulator on that clock edge.

A mode input decides whether the link bit takes part. With the mode clear, the operation acts on the accumulator alone and the link bit keeps its value. With the mode set, the link bit acts as a ninth bit. Rotates then run through nine bits, and shifts move a bit into or out of the link.

Accumulators and the link are loaded through a write port. Any accumulator can be read through a combinational read port, and the link value is an output. An execute strobe takes priority over a load in the same cycle.

Top module: `shrot_unit`

## Requirements
- R1: After reset every accumulator and the link bit read as zero.
- R2: With exec_en low, load_en high writes load_data into accumulator load_idx at the next edge, and link_wr_en high writes link_wr_val into the link at the next edge.
- R3: exec_op selects the operation: bit 1 high means rotate and low means shift; bit 0 high means right and low means left (00 shift left, 01 shift right, 10 rotate left, 11 rotate right). Rotate left with link_mode low writes {a[6:0], a[7]}.
- R4: Rotate left with link_mode high writes {a[6:0], link} and loads a[7] into the link.
- R5: Rotate right writes {a[0], a[7:1]} with link_mode low. With link_mode high it writes {link, a[7:1]} and loads a[0] into the link.
- R6: Shift left writes {a[6:0], 0} in both modes. With link_mode high, a[7] is loaded into the link.
- R7: Shift right with link_mode low writes {0, a[7:1]}, so bit 0 is lost.
- R8: Shift right with link_mode high writes {link, a[7:1]} and clears the link.
- R9: With link_mode low the link keeps its value across all four operations.
- R10: An operation changes only the accumulator named by exec_idx. When neither a load nor an operation is requested, all accumulators keep their values.
- R11: When exec_en is high, load_en and link_wr_en in the same cycle have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_en | input | 1 | Perform the selected operation at this edge |
| exec_op | input | 2 | Operation select: bit 1 rotate, bit 0 right |
| exec_idx | input | 2 | Accumulator operated on |
| link_mode | input | 1 | Include the link bit as a ninth bit |
| load_en | input | 1 | Write load_data into an accumulator |
| load_idx | input | 2 | Accumulator to load |
| load_data | input | 8 | Load value |
| link_wr_en | input | 1 | Write the link bit |
| link_wr_val | input | 1 | Value for the link bit |
| rd_idx | input | 2 | Accumulator read selector |
| rd_data | output | 8 | Contents of accumulator rd_idx |
| link | output | 1 | Current link bit |

## Verification
Several properties are checked on every cycle. In plain mode, the link holds and rotates keep the count of one bits. In link mode, rotates keep the count of one bits across the nine bits. Shift left always leaves bit 0 clear, and shift right in link mode always clears the link. An idle cycle leaves the whole bank unchanged. The exact result of each operation for every operand value, link value and mode, the isolation of the other accumulators, and the priority of execute over load can only be shown by the bench's sweep, which drives all of them and compares against an arithmetic model.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    typedef enum logic [1:0] {
        OP_SHL = 2'b00,
        OP_SHR = 2'b01,
        OP_ROL = 2'b10,
        OP_ROR = 2'b11
    } shrot_op_e;

    typedef struct packed {
        logic      link_mode;
        shrot_op_e op;
    } shrot_ctrl_t;

endpackage

// File: rtl/shrot_core.sv
module shrot_core
    import shrot_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] operand,
    input  logic             link_in,
    input  shrot_ctrl_t      ctrl,
    output logic [WIDTH-1:0] result,
    output logic             link_out
);

    localparam int MSB = WIDTH - 1;

    logic left_fill;
    logic right_fill;

    // Bit entering at the low end on a left move, and at the high end on a right move
    always_comb begin
        left_fill  = 1'b0;
        right_fill = 1'b0;
        unique case (ctrl.op)
            OP_ROL:  left_fill  = ctrl.link_mode ? link_in : operand[MSB];
            OP_ROR:  right_fill = ctrl.link_mode ? link_in : operand[0];
            OP_SHR:  right_fill = ctrl.link_mode ? link_in : 1'b0;
            default: left_fill  = 1'b0;
        endcase
    end

    always_comb begin
        link_out = link_in;
        if (ctrl.op[0]) begin
            result = {right_fill, operand[MSB:1]};
        end else begin
            result = {operand[MSB-1:0], left_fill};
        end
        if (ctrl.link_mode) begin
            unique case (ctrl.op)
                OP_ROL, OP_SHL: link_out = operand[MSB];
                OP_ROR:         link_out = operand[0];
                default:        link_out = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/shrot_regfile.sv
module shrot_regfile #(
    parameter int WIDTH   = 8,
    parameter int NUM_ACC = 4,
    localparam int IDX_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [IDX_W-1:0]               wr_idx,
    input  logic [WIDTH-1:0]               wr_data,
    output logic [NUM_ACC-1:0][WIDTH-1:0]  acc_all
);

    logic [NUM_ACC-1:0][WIDTH-1:0] acc_d;
    logic [NUM_ACC-1:0][WIDTH-1:0] acc_q;

    genvar g;
    generate
        for (g = 0; g < NUM_ACC; g++) begin : g_acc
            always_comb begin
                acc_d[g] = acc_q[g];
                if (wr_en && (wr_idx == IDX_W'(g))) begin
                    acc_d[g] = wr_data;
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_d;
        end
    end

    assign acc_all = acc_q;

    AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(acc_q)); // R10

endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
#(
    parameter int WIDTH   = 8,
    parameter int NUM_ACC = 4,
    localparam int IDX_W  = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             exec_en,
    input  logic [1:0]       exec_op,
    input  logic [IDX_W-1:0] exec_idx,
    input  logic             link_mode,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [WIDTH-1:0] load_data,
    input  logic             link_wr_en,
    input  logic             link_wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [WIDTH-1:0] rd_data,
    output logic             link
);

    typedef struct packed {
        logic link;
    } unit_state_t;

    unit_state_t st_d;
    unit_state_t st_q;

    logic [NUM_ACC-1:0][WIDTH-1:0] acc_all;
    logic [WIDTH-1:0]              operand;
    logic [WIDTH-1:0]              core_res;
    logic                          core_link;
    shrot_ctrl_t                   ctrl;
    logic                          wr_en;
    logic [IDX_W-1:0]              wr_idx;
    logic [WIDTH-1:0]              wr_data;

    assign ctrl.link_mode = link_mode;
    assign ctrl.op        = shrot_op_e'(exec_op);
    assign operand        = acc_all[exec_idx];

    shrot_core #(.WIDTH(WIDTH)) u_core (
        .operand  (operand),
        .link_in  (st_q.link),
        .ctrl     (ctrl),
        .result   (core_res),
        .link_out (core_link)
    );

    // Execute wins over the load and link write ports
    always_comb begin
        st_d    = st_q;
        wr_en   = 1'b0;
        wr_idx  = load_idx;
        wr_data = load_data;
        if (exec_en) begin
            wr_en     = 1'b1;
            wr_idx    = exec_idx;
            wr_data   = core_res;
            st_d.link = core_link;
        end else begin
            wr_en = load_en;
            if (link_wr_en) begin
                st_d.link = link_wr_val;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    shrot_regfile #(.WIDTH(WIDTH), .NUM_ACC(NUM_ACC)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .acc_all (acc_all)
    );

    assign rd_data = acc_all[rd_idx];
    assign link    = st_q.link;

    AST_PLAIN_LINK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !link_mode) |=> (link == $past(link))); // R9

    AST_PLAIN_ROT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && !link_mode && exec_op[1]) |=>
        ($countones(acc_all[$past(exec_idx)]) == $countones($past(operand)))); // R3

    AST_NINE_BIT_ROT_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && link_mode && exec_op[1]) |=>
        ($countones({link, acc_all[$past(exec_idx)]}) ==
         $countones({$past(link), $past(operand)}))); // R4

    AST_SHL_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && exec_op == 2'b00) |=> (acc_all[$past(exec_idx)][0] == 1'b0)); // R6

    AST_SHR_LINK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_en && link_mode && exec_op == 2'b01) |=> (link == 1'b0)); // R8

endmodule

// File: tb/shrot_unit_test.sv
module shrot_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       exec_en = 1'b0;
    logic [1:0] exec_op = 2'b00;
    logic [1:0] exec_idx = 2'b00;
    logic       link_mode = 1'b0;
    logic       load_en = 1'b0;
    logic [1:0] load_idx = 2'b00;
    logic [7:0] load_data = 8'h00;
    logic       link_wr_en = 1'b0;
    logic       link_wr_val = 1'b0;
    logic [1:0] rd_idx = 2'b00;
    logic [7:0] rd_data;
    logic       link;

    int total = 0;
    int bad = 0;
    int model[4];
    int model_link;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    shrot_unit uut (
        .clk(clk), .rst_n(rst_n), .exec_en(exec_en), .exec_op(exec_op),
        .exec_idx(exec_idx), .link_mode(link_mode), .load_en(load_en),
        .load_idx(load_idx), .load_data(load_data), .link_wr_en(link_wr_en),
        .link_wr_val(link_wr_val), .rd_idx(rd_idx), .rd_data(rd_data), .link(link)
    );

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic read_acc(input int idx, output int val);
        rd_idx = 2'(idx);
        #1;
        val = int'(rd_data);
    endtask

    task automatic check_bank(input string req);
        for (int k = 0; k < 4; k++) begin
            int v;
            read_acc(k, v);
            check(req, v, model[k]);
        end
        check(req, int'(link), model_link);
    endtask

    // Expected result of one operation, computed arithmetically
    task automatic predict(input int op, input int a, input int lk, input int sel,
                           output int res, output int nlk);
        nlk = sel ? lk : lk;
        case (op)
            0: begin res = (a * 2) % 256; if (sel) nlk = a / 128; end
            1: begin res = a / 2 + ((sel && lk) ? 128 : 0); if (sel) nlk = 0; end
            2: begin res = (a * 2) % 256 + (sel ? lk : a / 128); if (sel) nlk = a / 128; end
            default: begin
                res = a / 2 + 128 * (sel ? lk : a % 2);
                if (sel) nlk = a % 2;
            end
        endcase
    endtask

    function automatic string op_req(input int op, input int sel);
        case (op)
            0: return "R6";
            1: return sel ? "R8" : "R7";
            2: return sel ? "R4" : "R3";
            default: return "R5";
        endcase
    endfunction

    initial begin
        repeat (2000000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) model[k] = 0;
        model_link = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bank("R1");

        // Fill the bank with distinct values (R2)
        for (int k = 0; k < 4; k++) begin
            load_en = 1'b1; load_idx = 2'(k); load_data = 8'(17 * k + 5);
            @(negedge clk);
            model[k] = 17 * k + 5;
        end
        load_en = 1'b0;
        link_wr_en = 1'b1; link_wr_val = 1'b1;
        @(negedge clk);
        link_wr_en = 1'b0;
        model_link = 1;
        check_bank("R2");

        // Idle cycles keep everything (R10)
        repeat (3) @(negedge clk);
        check_bank("R10");

        // Full sweep: every operand, op, mode and link value
        for (int a = 0; a < 256; a++) begin
            for (int op = 0; op < 4; op++) begin
                for (int sel = 0; sel < 2; sel++) begin
                    for (int lk = 0; lk < 2; lk++) begin
                        int idx;
                        int res;
                        int nlk;
                        int v;
                        idx = (a + op + sel) % 4;
                        load_en = 1'b1; load_idx = 2'(idx); load_data = 8'(a);
                        link_wr_en = 1'b1; link_wr_val = lk[0];
                        @(negedge clk);
                        model[idx] = a; model_link = lk;
                        load_en = 1'b0; link_wr_en = 1'b0;
                        exec_en = 1'b1; exec_op = 2'(op); exec_idx = 2'(idx);
                        link_mode = sel[0];
                        @(negedge clk);
                        exec_en = 1'b0;
                        predict(op, a, lk, sel, res, nlk);
                        model[idx] = res;
                        read_acc(idx, v);
                        check(op_req(op, sel), v, res);
                        check(sel ? op_req(op, sel) : "R9", int'(link), nlk);
                        model_link = nlk;
                        if (a % 32 == 0) check_bank("R10");
                    end
                end
            end
        end

        // Execute and load in the same cycle: load and link write ignored (R11)
        begin
            int res;
            int nlk;
            predict(2, model[1], model_link, 0, res, nlk);
            exec_en = 1'b1; exec_op = 2'b10; exec_idx = 2'd1; link_mode = 1'b0;
            load_en = 1'b1; load_idx = 2'd1; load_data = 8'hA5;
            link_wr_en = 1'b1; link_wr_val = ~link;
            @(negedge clk);
            exec_en = 1'b0; load_en = 1'b0; link_wr_en = 1'b0;
            model[1] = res;
            check_bank("R11");
            exec_en = 1'b1; exec_op = 2'b01; exec_idx = 2'd2; link_mode = 1'b0;
            load_en = 1'b1; load_idx = 2'd3; load_data = 8'h3C;
            predict(1, model[2], model_link, 0, res, nlk);
            @(negedge clk);
            exec_en = 1'b0; load_en = 1'b0;
            model[2] = res;
            check_bank("R11");
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule